// File: doc/BRIEF.md
# Interleaved-Bank Vector Load/Store Unit

This block moves a whole vector of words between a register-side port and a word memory that is split across several independent banks. A vector operation is started with a base word address, a signed word stride and an element count. Element `i` lives at `base + i*stride`, and the address wraps around the memory size. Its bank is the low address bits and its row within that bank is the remaining upper bits. The unit tries to start one element access per clock. Each bank needs a recovery time after every access, so a stride that lands twice on the same bank too soon stalls the stream until that bank is free again.

A load sends every accessed word through a fixed-latency pipeline tagged with its element index. The words come out in element order on a valid/ready port, and back-pressure on that port freezes the pipeline and stops new accesses. A store takes its words from a valid/ready input in element order and writes each word at its handshake. A one-cycle done pulse closes each operation. The memory contents reset to zero.

Top module: `banked_vec_lsu`

## Requirements
- R1: While reset is held and in the first cycle after it, `ld_valid_o`, `st_ready_o` and `done_o` are low.
- R2: When the first element's bank is free, the first load word is valid exactly `LAT` (12) cycles after the clock edge that accepts `start_i`.
- R3: Element `i` is at word address `(base_i + i*stride_i) mod NBANK*ROWS`, where `stride_i` is two's complement. Its bank is `address mod NBANK` and its row is `address / NBANK`. A load returns the word most recently stored at that address, or zero if nothing has been stored there.
- R4: With no bank conflicts and `ld_ready_i` held high, load words are delivered on consecutive cycles, one per clock.
- R5: Two accesses to the same bank are at least `BUSY` (7) cycles apart. While the current element's bank is busy, that element is held and nothing is issued.
- R6: Load words come out in increasing element order, starting at 0. `ld_index_o` gives each word's element number.
- R7: While `ld_valid_o` is high and `ld_ready_i` is low, `ld_valid_o`, `ld_data_o` and `ld_index_o` hold their values and no new access is issued.
- R8: In a store operation, `st_ready_o` is high exactly when the current element's bank is free and elements remain. The word on `st_data_i` is written when `st_valid_i` and `st_ready_o` are both high. In a load operation `st_ready_o` stays low.
- R9: `done_o` is a single-cycle pulse in the cycle after the last load word is delivered or the last store word is accepted. A count of zero gives the pulse in the cycle after `start_i` is accepted, with no access made.
- R10: `start_i` has no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| store_i | input | 1 | 1 = store operation, 0 = load operation |
| base_i | input | AW | First element word address |
| stride_i | input | AW | Signed word stride |
| len_i | input | LW | Element count |
| done_o | output | 1 | Operation-complete pulse |
| st_valid_i | input | 1 | Store word offered |
| st_data_i | input | DW | Store word |
| st_ready_o | output | 1 | Store word can be accepted this cycle |
| ld_valid_o | output | 1 | Load word available |
| ld_ready_i | input | 1 | Consumer takes the load word |
| ld_data_o | output | DW | Load word |
| ld_index_o | output | LW | Element number of the load word |

## Verification
The bench instantiates the unit with its default parameters: eight banks of sixteen rows, a latency of 12 and a bank recovery time of 7. At these values a stride of 8 or 0 puts every access on a single bank, and a stride of 4 alternates between two banks that are each reused before they recover. A stride of 1 never conflicts, and a stride of -1 wraps below address zero. Together these cover the full stall, the partial stall, the conflict-free one-per-clock stream and address wrap. The 128-word memory is small enough to fill completely with one store and then read back over many stride patterns.

// File: rtl/vlsu_pkg.sv
// Shared definitions for the banked vector load/store unit.
// Assumes: nothing beyond standard SystemVerilog.
package vlsu_pkg;

    // Operation state of the sequencer.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2
    } vlsu_op_e;

endpackage

// File: rtl/vlsu_bank_timer.sv
// Per-bank recovery timers. An access to a bank reloads that bank's timer
// with BUSY-1, and the timer then counts down once per clock. A bank is
// reported free only when its timer reads zero.
// Assumes: NBANK is a power of two, at least 2; BUSY is at least 1.
module vlsu_bank_timer #(
    parameter int NBANK = 8,
    parameter int BUSY  = 7,
    localparam int BB   = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [BB-1:0]    hit_bank_i,
    output logic [NBANK-1:0] free_o
);
    localparam int CW = $clog2(BUSY) + 1;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CW-1:0] cnt_q;

        // Reload on access, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit_i && hit_bank_i == BB'(b)) begin
                cnt_q <= CW'(BUSY - 1);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        // A bank is free when its timer has run out.
        assign free_o[b] = (cnt_q == '0);
    end

endmodule

// File: rtl/vlsu_bank_array.sv
// Word storage split across NBANK banks of ROWS words each. The low address
// bits pick the bank and the upper bits pick the row. Reads are
// combinational; writes land on the clock edge. All words reset to zero.
// Assumes: NBANK and ROWS are powers of two, each at least 2.
module vlsu_bank_array #(
    parameter int NBANK = 8,
    parameter int ROWS  = 16,
    parameter int DW    = 32,
    localparam int BB   = $clog2(NBANK),
    localparam int RB   = $clog2(ROWS),
    localparam int AW   = BB + RB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [BB-1:0] bank_sel;
    logic [RB-1:0] row_sel;
    logic [DW-1:0] bank_rd [NBANK];

    assign bank_sel = addr_i[BB-1:0];
    assign row_sel  = addr_i[AW-1:BB];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem_q [ROWS];

        // Clear on reset, write the addressed row when this bank is hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    mem_q[r] <= '0;
                end
            end else if (we_i && bank_sel == BB'(b)) begin
                mem_q[row_sel] <= wdata_i;
            end
        end

        // Each bank presents the addressed row.
        assign bank_rd[b] = mem_q[row_sel];
    end

    // The addressed bank drives the read data.
    assign rdata_o = bank_rd[bank_sel];

endmodule

// File: rtl/vlsu_lat_pipe.sv
// Fixed-depth latency pipeline carrying a valid bit, an element index and
// a data word. The whole pipeline moves one stage when adv_i is high and
// holds every stage otherwise.
// Assumes: DEPTH is at least 2; the caller offers a new entry only when
// adv_i is high.
module vlsu_lat_pipe #(
    parameter int DEPTH = 12,
    parameter int IW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          in_valid_i,
    input  logic [IW-1:0] in_idx_i,
    input  logic [DW-1:0] in_data_i,
    output logic          out_valid_o,
    output logic [IW-1:0] out_idx_o,
    output logic [DW-1:0] out_data_o
);
    logic          v_q   [DEPTH];
    logic [IW-1:0] idx_q [DEPTH];
    logic [DW-1:0] dat_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // The first stage takes the new entry on every advance.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                end else if (adv_i) begin
                    v_q[0] <= in_valid_i;
                end
            end

            // Payload of the first stage (not reset).
            always_ff @(posedge clk) begin
                if (adv_i) begin
                    idx_q[0] <= in_idx_i;
                    dat_q[0] <= in_data_i;
                end
            end
        end else begin : g_body
            // Later stages copy their predecessor on every advance.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[s] <= 1'b0;
                end else if (adv_i) begin
                    v_q[s] <= v_q[s-1];
                end
            end

            // Payload of a later stage (not reset).
            always_ff @(posedge clk) begin
                if (adv_i) begin
                    idx_q[s] <= idx_q[s-1];
                    dat_q[s] <= dat_q[s-1];
                end
            end
        end
    end

    assign out_valid_o = v_q[DEPTH-1];
    assign out_idx_o   = idx_q[DEPTH-1];
    assign out_data_o  = dat_q[DEPTH-1];

endmodule

// File: rtl/banked_vec_lsu.sv
// Vector load/store sequencer over an interleaved multi-bank memory.
// It walks element addresses base + i*stride, one access per clock, and
// holds the current element whenever its bank is still recovering. Loads
// pass through a LAT-deep pipeline to a valid/ready output. Stores take
// words from a valid/ready input.
// Assumes: NBANK and ROWS are powers of two, each at least 2; LAT is at
// least 2; BUSY is at least 1.
module banked_vec_lsu #(
    parameter int NBANK = 8,
    parameter int ROWS  = 16,
    parameter int DW    = 32,
    parameter int LW    = 8,
    parameter int LAT   = 12,
    parameter int BUSY  = 7,
    localparam int BB   = $clog2(NBANK),
    localparam int AW   = BB + $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          store_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] stride_i,
    input  logic [LW-1:0] len_i,
    output logic          done_o,
    input  logic          st_valid_i,
    input  logic [DW-1:0] st_data_i,
    output logic          st_ready_o,
    output logic          ld_valid_o,
    input  logic          ld_ready_i,
    output logic [DW-1:0] ld_data_o,
    output logic [LW-1:0] ld_index_o
);
    import vlsu_pkg::*;

    vlsu_op_e      op_q;
    logic [LW-1:0] vlen_q;
    logic [LW-1:0] issued_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] stride_q;
    logic          done_q;

    logic [NBANK-1:0] bank_free;
    logic [BB-1:0]    issue_bank;
    logic             bank_ok;
    logic             elems_left;
    logic             pipe_adv;
    logic             ld_fire;
    logic             st_fire;
    logic             acc_fire;
    logic             deliver;
    logic             last_deliver;
    logic             last_store;
    logic [DW-1:0]    rd_word;

    // Access decision for the current element.
    always_comb begin
        issue_bank   = addr_q[BB-1:0];
        bank_ok      = bank_free[issue_bank];
        elems_left   = (op_q != OP_IDLE) && (issued_q != vlen_q);
        pipe_adv     = !ld_valid_o || ld_ready_i;
        ld_fire      = (op_q == OP_LOAD) && elems_left && bank_ok && pipe_adv;
        st_ready_o   = (op_q == OP_STORE) && elems_left && bank_ok;
        st_fire      = st_ready_o && st_valid_i;
        acc_fire     = ld_fire || st_fire;
        deliver      = ld_valid_o && ld_ready_i;
        last_deliver = deliver && (ld_index_o == vlen_q - 1'b1);
        last_store   = st_fire && (issued_q == vlen_q - 1'b1);
    end

    // Sequencer: accept a start when idle, step the address, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            vlen_q   <= '0;
            issued_q <= '0;
            addr_q   <= '0;
            stride_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op_q == OP_IDLE && start_i) begin
                if (len_i == '0) begin
                    done_q <= 1'b1;
                end else begin
                    op_q     <= store_i ? OP_STORE : OP_LOAD;
                    vlen_q   <= len_i;
                    issued_q <= '0;
                    addr_q   <= base_i;
                    stride_q <= stride_i;
                end
            end
            if (acc_fire) begin
                issued_q <= issued_q + 1'b1;
                addr_q   <= addr_q + stride_q;
            end
            if (last_store || last_deliver) begin
                op_q   <= OP_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    assign done_o = done_q;

    vlsu_bank_timer #(
        .NBANK (NBANK),
        .BUSY  (BUSY)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (acc_fire),
        .hit_bank_i (issue_bank),
        .free_o     (bank_free)
    );

    vlsu_bank_array #(
        .NBANK (NBANK),
        .ROWS  (ROWS),
        .DW    (DW)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_fire),
        .addr_i  (addr_q),
        .wdata_i (st_data_i),
        .rdata_o (rd_word)
    );

    vlsu_lat_pipe #(
        .DEPTH (LAT),
        .IW    (LW),
        .DW    (DW)
    ) i_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (pipe_adv),
        .in_valid_i  (ld_fire),
        .in_idx_i    (issued_q),
        .in_data_i   (rd_word),
        .out_valid_o (ld_valid_o),
        .out_idx_o   (ld_index_o),
        .out_data_o  (ld_data_o)
    );

endmodule

// File: rtl/banked_vec_lsu_chk.sv
// Property checker for banked_vec_lsu, attached by bind. It watches the
// ports and the access strobe and bank number that the sequencer hands to
// the bank timers.
// Assumes: it is bound into banked_vec_lsu with matching parameters.
module banked_vec_lsu_chk #(
    parameter int NBANK = 8,
    parameter int BUSY  = 7,
    parameter int DW    = 32,
    parameter int LW    = 8,
    localparam int BB   = $clog2(NBANK)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done_o,
    input logic          st_ready_o,
    input logic          ld_valid_o,
    input logic          ld_ready_i,
    input logic [DW-1:0] ld_data_o,
    input logic [LW-1:0] ld_index_o,
    input logic          acc_fire,
    input logic [BB-1:0] issue_bank
);
    localparam int GW = $clog2(BUSY + 1) + 1;

    logic [LW-1:0] want_idx_q;

    // Element number the next delivered load word should carry.
    always_ff @(posedge clk) begin
        if (!rst_n || done_o) begin
            want_idx_q <= '0;
        end else if (ld_valid_o && ld_ready_i) begin
            want_idx_q <= want_idx_q + 1'b1;
        end
    end

    // R7: a stalled output word holds still.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o && !ld_ready_i |=> ld_valid_o && $stable(ld_data_o) && $stable(ld_index_o));

    // R6: words leave in element order.
    p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> ld_index_o == want_idx_q);

    // R9: done never lasts two cycles.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: store readiness never overlaps a pending load word.
    p_store_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready_o |-> !ld_valid_o);

    for (genvar b = 0; b < NBANK; b++) begin : g_gap
        logic [GW-1:0] gap_q;
        logic          seen_q;

        // Cycles elapsed since this bank's last access, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q  <= '0;
                seen_q <= 1'b0;
            end else if (acc_fire && issue_bank == BB'(b)) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q < GW'(BUSY)) begin
                gap_q <= gap_q + 1'b1;
            end
        end

        // R5: a bank is not touched again before it recovers.
        p_bank_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            acc_fire && issue_bank == BB'(b) && seen_q |-> gap_q >= GW'(BUSY - 1));
    end

endmodule

bind banked_vec_lsu banked_vec_lsu_chk #(
    .NBANK (NBANK),
    .BUSY  (BUSY),
    .DW    (DW),
    .LW    (LW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .st_ready_o (st_ready_o),
    .ld_valid_o (ld_valid_o),
    .ld_ready_i (ld_ready_i),
    .ld_data_o  (ld_data_o),
    .ld_index_o (ld_index_o),
    .acc_fire   (acc_fire),
    .issue_bank (issue_bank)
);

// File: tb/test_banked_vec_lsu.sv
// Bench for banked_vec_lsu: a behavioural reference model stepped on every
// clock and compared on every falling edge, plus directed timing checks.
module test_banked_vec_lsu;
    localparam int NB   = 8;
    localparam int ROWS = 16;
    localparam int DW   = 32;
    localparam int LW   = 8;
    localparam int LAT  = 12;
    localparam int BUSY = 7;
    localparam int AW   = $clog2(NB * ROWS);
    localparam int MASK = NB * ROWS - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          store = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] stride = '0;
    logic [LW-1:0] len = '0;
    logic          done;
    logic          st_valid = 1'b0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready;
    logic          ld_valid;
    logic          ld_ready = 1'b1;
    logic [DW-1:0] ld_data;
    logic [LW-1:0] ld_index;

    banked_vec_lsu #(
        .NBANK (NB), .ROWS (ROWS), .DW (DW), .LW (LW), .LAT (LAT), .BUSY (BUSY)
    ) i_banked_vec_lsu (
        .clk (clk), .rst_n (rst_n), .start_i (start), .store_i (store),
        .base_i (base), .stride_i (stride), .len_i (len), .done_o (done),
        .st_valid_i (st_valid), .st_data_i (st_data), .st_ready_o (st_ready),
        .ld_valid_o (ld_valid), .ld_ready_i (ld_ready), .ld_data_o (ld_data),
        .ld_index_o (ld_index)
    );

    always #5 clk = ~clk;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int start_cyc = 0;
    int first_cyc = -1;
    int hold_seen = 0;
    int dl_t[$];
    bit finished = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct {
        int            idx;
        logic [DW-1:0] data;
        int            cnt;
    } ent_t;

    ent_t          q[$];
    int            m_mode, m_len, m_issued, m_addr, m_stride;
    bit            m_done;
    int            bcnt[NB];
    logic [DW-1:0] mm[NB*ROWS];
    bit            hold_pend = 0;
    logic [DW-1:0] hold_data;
    logic [LW-1:0] hold_idx;

    always @(posedge clk) begin
        bit out_v, adv, want, bfree, ldf, stf, nd, st_acc;
        int bk;
        if (!rst_n) begin
            q.delete();
            m_mode = 0; m_len = 0; m_issued = 0; m_addr = 0; m_stride = 0; m_done = 0;
            foreach (bcnt[b]) bcnt[b] = 0;
            foreach (mm[a]) mm[a] = '0;
            hold_pend = 0;
        end else begin
            if (ld_valid && ld_ready) dl_t.push_back(cyc);
            hold_pend = ld_valid && !ld_ready;
            hold_data = ld_data;
            hold_idx  = ld_index;
            out_v  = q.size() > 0 && q[0].cnt == 0;
            adv    = !out_v || ld_ready;
            want   = m_mode != 0 && m_issued < m_len;
            bk     = m_addr % NB;
            bfree  = bcnt[bk] == 0;
            ldf    = m_mode == 1 && want && bfree && adv;
            stf    = m_mode == 2 && want && bfree && st_valid;
            st_acc = m_mode == 0 && start;
            nd     = 0;
            if (out_v && ld_ready) begin
                if (q[0].idx == m_len - 1) begin nd = 1; m_mode = 0; end
                void'(q.pop_front());
            end
            if (adv) foreach (q[i]) if (q[i].cnt > 0) q[i].cnt--;
            foreach (bcnt[b]) if (bcnt[b] > 0) bcnt[b]--;
            if (ldf || stf) begin
                bcnt[bk] = BUSY - 1;
                if (ldf) q.push_back('{idx: m_issued, data: mm[m_addr], cnt: LAT - 1});
                if (stf) begin
                    mm[m_addr] = st_data;
                    if (m_issued == m_len - 1) begin nd = 1; m_mode = 0; end
                end
                m_issued++;
                m_addr = (m_addr + m_stride) & MASK;
            end
            if (st_acc) begin
                if (len == 0) nd = 1;
                else begin
                    m_mode = store ? 2 : 1; m_len = int'(len); m_issued = 0;
                    m_addr = int'(base); m_stride = int'(stride);
                end
            end
            m_done = nd;
        end
        cyc++;
    end

    // Compare outputs with the model away from the rising edge.
    always @(negedge clk) begin
        bit exp_v, exp_sr;
        if (rst_n && !finished) begin
            exp_v  = q.size() > 0 && q[0].cnt == 0;
            exp_sr = m_mode == 2 && m_issued < m_len && bcnt[m_addr % NB] == 0;
            chk(ld_valid == exp_v, "R4", "ld_valid", ld_valid, exp_v);
            if (exp_v && ld_valid) begin
                chk(ld_index == LW'(q[0].idx), "R6", "ld_index", ld_index, q[0].idx);
                chk(ld_data == q[0].data, "R3", "ld_data", ld_data, q[0].data);
            end
            chk(st_ready == exp_sr, "R8", "st_ready", st_ready, exp_sr);
            chk(done == m_done, "R9", "done", done, m_done);
            if (hold_pend) begin
                hold_seen++;
                chk(ld_valid && ld_data == hold_data && ld_index == hold_idx,
                    "R7", "stalled word held", ld_index, hold_idx);
            end
            if (ld_valid && first_cyc < 0) first_cyc = cyc;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(negedge clk) begin
        if (cyc > 60000 && !finished) begin
            finished = 1;
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_vec(bit st, int b, int s, int n);
        @(negedge clk);
        start = 1; store = st; base = AW'(b); stride = AW'(s); len = LW'(n);
        @(negedge clk);
        start = 0;
        start_cyc = cyc; first_cyc = -1; dl_t.delete();
    endtask

    // Run a load to its done pulse; rmode 1 throttles ld_ready.
    task automatic run_load(int b, int s, int n, int rmode);
        start_vec(0, b, s, n);
        forever begin
            if (done) break;
            ld_ready = (rmode == 0) ? 1'b1 : (((cyc * 7) % 3) != 0);
            @(negedge clk);
        end
        ld_ready = 1;
    endtask

    task automatic run_store(int b, int s, int n, int seed);
        bit pv = 0, pr = 0;
        int k = 0;
        start_vec(1, b, s, n);
        forever begin
            if (pv && pr) k++;
            if (done) break;
            st_valid = (cyc % 5) != 0;
            st_data  = DW'(k * 32'h9E37 + seed) ^ 32'hA5A5_0000;
            pv = st_valid; pr = st_ready;
            @(negedge clk);
        end
        st_valid = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs low while reset is held.
        chk(!ld_valid && !st_ready && !done, "R1", "outputs in reset", {ld_valid, st_ready, done}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!ld_valid && !st_ready && !done, "R1", "outputs after reset", {ld_valid, st_ready, done}, 0);

        // Fill the whole memory, then overwrite part with stride 2.
        run_store(0, 1, NB * ROWS, 17);
        idle(10);
        run_store(1, 2, 20, 301);
        idle(10);

        // R2 and R4: conflict-free stream.
        run_load(5, 1, 16, 0);
        chk(first_cyc - start_cyc == LAT, "R2", "start-up latency", first_cyc - start_cyc, LAT);
        chk(dl_t.size() == 16 && dl_t[$] - dl_t[0] == 15, "R4", "one word per clock",
            dl_t[$] - dl_t[0], 15);
        idle(10);

        // R5: every element on bank 3.
        run_load(3, 8, 4, 0);
        for (int i = 1; i < 4; i++)
            chk(dl_t[i] - dl_t[i-1] == BUSY, "R5", "same-bank spacing", dl_t[i] - dl_t[i-1], BUSY);
        idle(10);

        // R3: negative stride wrapping below zero.
        run_load(2, -1, 20, 0);
        idle(10);
        // R5: zero stride, then two alternating banks.
        run_load(9, 0, 3, 0);
        idle(10);
        run_load(0, 4, 10, 0);
        idle(10);

        // R7: throttled consumer over a stride-3 walk.
        run_load(10, 3, 30, 1);
        chk(hold_seen > 0, "R7", "back-pressure exercised", hold_seen, 1);
        idle(10);

        // R10: a second start during a load is ignored.
        start_vec(0, 7, 5, 12);
        idle(4);
        start = 1; store = 1; base = AW'(0); stride = AW'(1); len = LW'(3);
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        chk(dl_t.size() == 12, "R10", "words delivered", dl_t.size(), 12);
        idle(3);
        chk(!st_ready && !ld_valid, "R10", "no store started", {st_ready, ld_valid}, 0);
        idle(10);

        // R9: zero-length vector.
        start_vec(0, 4, 1, 0);
        chk(done == 1, "R9", "zero-length done", done, 1);
        chk(!ld_valid && !st_ready, "R9", "no access", {ld_valid, st_ready}, 0);
        @(negedge clk);
        chk(done == 0, "R9", "done single cycle", done, 0);
        idle(20);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule